// File: doc/BRIEF.md
# Outbound Memory Window Address Translator

This block sits at the local-bus side of a host-to-PCI bridge. It turns accesses that fall into one of three outbound memory windows into addresses in a 32-bit PCI memory space. A small word-wide control register file holds eight registers. Three of them are window-map registers, one per window. The others are a bridge identity register, a flags register and three secondary-map registers. Software reaches the register file through separate read and write request channels, each with a valid/ready handshake.

To translate an access, a requester presents a window index and a local offset. One cycle later the block returns either a forwarded PCI address or an out-of-range pulse. A static strap input selects how the window base is formed. With the strap low, the low nibble of the window's map register becomes the top nibble of the PCI address. With the strap high, the map register is masked down to the window's size alignment. Each strap setting has its own set of three window sizes, given as parameters.

Top module: `pcibr_win_xlate`

## Requirements
- R1: After reset all eight registers read as zero, both ready outputs are high, and no translation result or error pulse is driven.
- R2: The register layout is: map registers 0, 1 and 2 at offsets 0x00, 0x04 and 0x08; identity at 0x0C; flags at 0x10; secondary-map registers 0, 1 and 2 at 0x14, 0x18 and 0x1C. A word write to a decoded offset stores the data. A word read of a decoded offset returns the stored value. Read data appears, with rd_dvalid high, in the cycle after the read is accepted.
- R3: An offset of 0x20 or above, or one whose two low bits are not zero, is undecoded. A read of it returns zero, and a write to it changes no register. Either access pulses cfg_err for one cycle, in the cycle after acceptance.
- R4: An access with the word-size flag low is not valid. Such a write changes no register, and such a read returns zero. Either access pulses cfg_err in the cycle after acceptance.
- R5: With strap_mask low, window i's base is map register i bits [3:0] placed at address bits [31:28], with all other bits zero. The window sizes are then 0x0C000000, 0x10000000 and 0x10000000.
- R6: With strap_mask high, window i's base is map register i ANDed with the inverse of (size_i - 1). The window sizes are then 0x01000000, 0x04000000 and 0x08000000.
- R7: A request (xl_valid high) with offset below its window's size produces xo_valid high one cycle later. In that cycle xo_addr equals the window base plus the offset, modulo 2^32, and xo_oor is low.
- R8: A request whose offset is at or above its window's size, or whose window index is 3, produces a one-cycle xo_oor pulse. In that cycle xo_valid is low and xo_addr is zero.
- R9: A map-register write accepted on one clock edge governs every translation request sampled on the following edge and later.
- R10: Writes to the identity, flags and secondary-map registers have no effect on any translated address or range decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_mask | input | 1 | Base-forming variant select, held static |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write channel ready |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_word | input | 1 | High for a full 32-bit access |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read channel ready |
| rd_addr | input | 12 | Read byte offset |
| rd_word | input | 1 | High for a full 32-bit access |
| rd_data | output | 32 | Read data |
| rd_dvalid | output | 1 | Read data valid pulse |
| cfg_err | output | 1 | Bad-access pulse |
| xl_valid | input | 1 | Translation request |
| xl_win | input | 2 | Window index |
| xl_off | input | 32 | Local offset within window |
| xo_valid | output | 1 | Forwarded translation result |
| xo_addr | output | 32 | Translated PCI address |
| xo_oor | output | 1 | Out-of-range pulse |

## Verification
Every result the block produces passes through exactly one register. Read data, rd_dvalid, cfg_err and the translation outputs all appear in the cycle after the edge that accepts the request. The bench drives each request on a falling edge and removes it on the next falling edge. It samples the matching outputs at that same falling edge, which is exactly one rising edge after the request was applied. The map-write ordering check places a translation request in the cycle right after the write is accepted, so it tests the earliest point at which the new value must be in effect.

// File: rtl/pcibr_pkg.sv
package pcibr_pkg;
  localparam int NWIN  = 3;
  localparam int NREG  = 8;
  localparam int WIN_W = 2;

  typedef enum logic [2:0] {
    RG_MAP0 = 3'd0,
    RG_MAP1 = 3'd1,
    RG_MAP2 = 3'd2,
    RG_IDENT = 3'd3,
    RG_FLAGS = 3'd4,
    RG_SEC0 = 3'd5,
    RG_SEC1 = 3'd6,
    RG_SEC2 = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic     hit;
    reg_sel_e sel;
  } dec_t;

  // Word offsets 0x00..0x1C decode to the eight registers; anything else misses.
  function automatic dec_t decode_off(input logic [31:0] off, input logic word);
    dec_t d;
    d.hit = word && (off[1:0] == 2'b00) && (off[31:5] == '0);
    d.sel = reg_sel_e'(off[4:2]);
    return d;
  endfunction
endpackage

// File: rtl/pcibr_cfg_regs.sv
module pcibr_cfg_regs
  import pcibr_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [OFF_W-1:0]  wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [OFF_W-1:0]  rd_addr,
  input  logic              rd_word,
  output logic [DW-1:0]     rd_data,
  output logic              rd_dvalid,
  output logic              cfg_err,
  output logic [NWIN*DW-1:0] map_flat
);
  logic [DW-1:0] regs [NREG];
  logic          rdy_q;
  logic          wr_acc, rd_acc;
  dec_t          wdec, rdec;

  assign wr_ready = rdy_q;
  assign rd_ready = rdy_q;
  assign wr_acc   = wr_valid && rdy_q;
  assign rd_acc   = rd_valid && rdy_q;

  always_comb begin
    wdec = decode_off(32'(wr_addr), wr_word);
    rdec = decode_off(32'(rd_addr), rd_word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_q     <= 1'b0;
      rd_data   <= '0;
      rd_dvalid <= 1'b0;
      cfg_err   <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      rdy_q     <= 1'b1;
      rd_dvalid <= rd_acc;
      cfg_err   <= (wr_acc && !wdec.hit) || (rd_acc && !rdec.hit);
      if (rd_acc) rd_data <= rdec.hit ? regs[rdec.sel] : '0;
      if (wr_acc && wdec.hit) regs[wdec.sel] <= wr_data;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_map_out
    assign map_flat[g*DW +: DW] = regs[g];
  end
endmodule

// File: rtl/pcibr_win_map.sv
module pcibr_win_map #(
  parameter int            DW      = 32,
  parameter logic [DW-1:0] SZ_NIB  = 32'h1000_0000,
  parameter logic [DW-1:0] SZ_MASK = 32'h0100_0000
) (
  input  logic          strap_mask,
  input  logic [DW-1:0] map_reg,
  input  logic [DW-1:0] off,
  output logic [DW-1:0] base,
  output logic          fits
);
  localparam logic [DW-1:0] MASK_KEEP = ~(SZ_MASK - 1'b1);
  localparam int            NIB_LSB   = DW - 4;

  logic [DW-1:0] size;

  always_comb begin
    size = strap_mask ? SZ_MASK : SZ_NIB;
    if (strap_mask) base = map_reg & MASK_KEEP;
    else            base = {map_reg[3:0], {NIB_LSB{1'b0}}};
    fits = off < size;
  end
endmodule

// File: rtl/pcibr_win_xlate.sv
module pcibr_win_xlate
  import pcibr_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            OFF_W    = 12,
  parameter logic [DW-1:0] SZ_NIB0  = 32'h0C00_0000,
  parameter logic [DW-1:0] SZ_NIB1  = 32'h1000_0000,
  parameter logic [DW-1:0] SZ_NIB2  = 32'h1000_0000,
  parameter logic [DW-1:0] SZ_MSK0  = 32'h0100_0000,
  parameter logic [DW-1:0] SZ_MSK1  = 32'h0400_0000,
  parameter logic [DW-1:0] SZ_MSK2  = 32'h0800_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_mask,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [OFF_W-1:0]  wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [OFF_W-1:0]  rd_addr,
  input  logic              rd_word,
  output logic [DW-1:0]     rd_data,
  output logic              rd_dvalid,
  output logic              cfg_err,
  input  logic              xl_valid,
  input  logic [WIN_W-1:0]  xl_win,
  input  logic [DW-1:0]     xl_off,
  output logic              xo_valid,
  output logic [DW-1:0]     xo_addr,
  output logic              xo_oor
);
  localparam logic [NWIN*DW-1:0] NIB_SIZES = {SZ_NIB2, SZ_NIB1, SZ_NIB0};
  localparam logic [NWIN*DW-1:0] MSK_SIZES = {SZ_MSK2, SZ_MSK1, SZ_MSK0};

  logic [NWIN*DW-1:0] map_flat;
  logic [DW-1:0]      w_base [NWIN];
  logic [NWIN-1:0]    w_fit;
  logic [DW-1:0]      sel_base;
  logic               sel_fit;
  logic               good;

  pcibr_cfg_regs #(.DW(DW), .OFF_W(OFF_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_data(rd_data), .rd_dvalid(rd_dvalid),
    .cfg_err(cfg_err), .map_flat(map_flat)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    pcibr_win_map #(
      .DW(DW),
      .SZ_NIB(NIB_SIZES[g*DW +: DW]),
      .SZ_MASK(MSK_SIZES[g*DW +: DW])
    ) u_map (
      .strap_mask(strap_mask),
      .map_reg(map_flat[g*DW +: DW]),
      .off(xl_off),
      .base(w_base[g]),
      .fits(w_fit[g])
    );
  end

  always_comb begin
    sel_base = '0;
    sel_fit  = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (32'(xl_win) == i) begin
        sel_base = w_base[i];
        sel_fit  = w_fit[i];
      end
    end
    good = xl_valid && sel_fit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xo_valid <= 1'b0;
      xo_oor   <= 1'b0;
      xo_addr  <= '0;
    end else begin
      xo_valid <= good;
      xo_oor   <= xl_valid && !sel_fit;
      xo_addr  <= good ? (sel_base + xl_off) : '0;
    end
  end
endmodule

// File: rtl/pcibr_chk.sv
module pcibr_chk #(
  parameter int DW    = 32,
  parameter int OFF_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [OFF_W-1:0] rd_addr,
  input logic [DW-1:0]    rd_data,
  input logic             rd_dvalid,
  input logic             cfg_err,
  input logic             xl_valid,
  input logic [1:0]       xl_win,
  input logic             xo_valid,
  input logic [DW-1:0]    xo_addr,
  input logic             xo_oor
);
  // R2: read data valid follows an accepted read by one cycle
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> rd_dvalid);
  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_ready) |=> !rd_dvalid);

  // R3: far offsets read as zero and flag an error
  assert_undecoded_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && (rd_addr >= OFF_W'(32))) |=> (rd_data == '0) && cfg_err);

  // R3/R4: no error without an accepted access
  assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && rd_ready) && !(wr_valid && wr_ready) |=> !cfg_err);

  // R7: every request yields exactly one outcome
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    xl_valid |=> (xo_valid ^ xo_oor));
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |=> (!xo_valid && !xo_oor));

  // R8: window index 3 is always out of range, and rejected results carry no address
  assert_bad_window_R8: assert property (@(posedge clk) disable iff (rst)
    (xl_valid && xl_win == 2'd3) |=> xo_oor);
  assert_oor_addr_R8: assert property (@(posedge clk) disable iff (rst)
    xo_oor |-> (xo_addr == '0));
endmodule

bind pcibr_win_xlate pcibr_chk #(.DW(DW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst),
  .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rd_data(rd_data), .rd_dvalid(rd_dvalid), .cfg_err(cfg_err),
  .xl_valid(xl_valid), .xl_win(xl_win),
  .xo_valid(xo_valid), .xo_addr(xo_addr), .xo_oor(xo_oor)
);

// File: tb/tb_pcibr_win_xlate.sv
module tb_pcibr_win_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_mask = 1'b0;
  logic        wr_valid = 1'b0, wr_word = 1'b1;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid = 1'b0, rd_word = 1'b1;
  logic [11:0] rd_addr = '0;
  logic        wr_ready, rd_ready, rd_dvalid, cfg_err;
  logic [31:0] rd_data;
  logic        xl_valid = 1'b0;
  logic [1:0]  xl_win = '0;
  logic [31:0] xl_off = '0;
  logic        xo_valid, xo_oor;
  logic [31:0] xo_addr;

  int total = 0;
  int bad   = 0;
  logic [31:0] shadow [8];

  always #10 clk = ~clk;

  pcibr_win_xlate dut (
    .clk(clk), .rst(rst), .strap_mask(strap_mask),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_word(rd_word), .rd_data(rd_data), .rd_dvalid(rd_dvalid),
    .cfg_err(cfg_err),
    .xl_valid(xl_valid), .xl_win(xl_win), .xl_off(xl_off),
    .xo_valid(xo_valid), .xo_addr(xo_addr), .xo_oor(xo_oor)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] win_size(input logic s, input int w);
    if (s) return (w == 0) ? 32'h0100_0000 : (w == 1) ? 32'h0400_0000 : 32'h0800_0000;
    return (w == 0) ? 32'h0C00_0000 : 32'h1000_0000;
  endfunction

  function automatic logic [31:0] win_base(input logic s, input int w, input logic [31:0] m);
    if (s) return m & ~(win_size(s, w) - 32'd1);
    return {m[3:0], 28'd0};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) shadow[i] = '0;
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [31:0] d, input logic word,
                       input logic exp_err, input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_word = word;
    @(negedge clk);
    wr_valid = 1'b0; wr_word = 1'b1;
    chk(cfg_err == exp_err, req, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic do_rd(input logic [11:0] a, input logic word, input logic [31:0] exp,
                       input logic exp_err, input string req);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = a; rd_word = word;
    @(negedge clk);
    rd_valid = 1'b0; rd_word = 1'b1;
    chk(rd_dvalid == 1'b1, req, 32'(rd_dvalid), 32'd1);
    chk(rd_data == exp, req, rd_data, exp);
    chk(cfg_err == exp_err, req, 32'(cfg_err), 32'(exp_err));
  endtask

  task automatic check_xl(input logic ok, input logic [31:0] ea, input string req);
    if (ok) begin
      chk(xo_valid && !xo_oor, req, {xo_valid, xo_oor}, 32'b10);
      chk(xo_addr == ea, req, xo_addr, ea);
    end else begin
      chk(xo_oor && !xo_valid, req, {xo_valid, xo_oor}, 32'b01);
    end
  endtask

  task automatic do_xl(input logic [1:0] w, input logic [31:0] off, input string req);
    logic        ok;
    logic [31:0] ea;
    ok = (w != 2'd3) && (off < win_size(strap_mask, int'(w)));
    ea = ok ? win_base(strap_mask, int'(w), shadow[w]) + off : 32'd0;
    @(negedge clk);
    xl_valid = 1'b1; xl_win = w; xl_off = off;
    @(negedge clk);
    xl_valid = 1'b0;
    check_xl(ok, ea, req);
  endtask

  task automatic sweep_windows(input string req);
    logic [31:0] maps [6];
    maps = '{32'h0, 32'h1, 32'h9, 32'hF, 32'hA5A5_A5A5, 32'hFFFF_FFFF};
    foreach (maps[k]) begin
      for (int w = 0; w < 3; w++) begin
        logic [31:0] sz;
        sz = win_size(strap_mask, w);
        do_wr(12'(w * 4), maps[k], 1'b1, 1'b0, req);
        shadow[w] = maps[k];
        do_xl(2'(w), 32'd0, req);
        do_xl(2'(w), sz - 32'd1, req);
        do_xl(2'(w), (sz >> 1) + 32'd13, req);
        do_xl(2'(w), sz, "R8 offset at size");
        do_xl(2'(w), 32'hFFFF_FFFF, "R8 offset max");
      end
      do_xl(2'd3, 32'd0, "R8 window 3");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(wr_ready && rd_ready, "R1 ready", {wr_ready, rd_ready}, 32'b11);
    chk(!xo_valid && !xo_oor && !cfg_err, "R1 idle outputs", {xo_valid, xo_oor, cfg_err}, 32'd0);
    for (int i = 0; i < 8; i++) do_rd(12'(i * 4), 1'b1, 32'd0, 1'b0, "R1 reset value");

    // R2 register layout: write distinct values, read them back
    for (int i = 0; i < 8; i++) begin
      shadow[i] = 32'h1000_0000 * i + 32'h0BAD_0000 + 32'(i * 7);
      do_wr(12'(i * 4), shadow[i], 1'b1, 1'b0, "R2 write");
    end
    for (int i = 0; i < 8; i++) do_rd(12'(i * 4), 1'b1, shadow[i], 1'b0, "R2 readback");

    // R3 undecoded offsets
    do_rd(12'h020, 1'b1, 32'd0, 1'b1, "R3 read 0x20");
    do_rd(12'hFFC, 1'b1, 32'd0, 1'b1, "R3 read 0xFFC");
    do_rd(12'h006, 1'b1, 32'd0, 1'b1, "R3 read unaligned");
    do_wr(12'h024, 32'hDEAD_BEEF, 1'b1, 1'b1, "R3 write far");
    do_wr(12'h001, 32'hDEAD_BEEF, 1'b1, 1'b1, "R3 write unaligned");
    for (int i = 0; i < 8; i++) do_rd(12'(i * 4), 1'b1, shadow[i], 1'b0, "R3 writes ignored");

    // R4 sub-word accesses
    do_wr(12'h000, 32'h5555_5555, 1'b0, 1'b1, "R4 narrow write");
    do_rd(12'h000, 1'b1, shadow[0], 1'b0, "R4 narrow write ignored");
    do_rd(12'h004, 1'b0, 32'd0, 1'b1, "R4 narrow read");

    // R5 nibble variant sweep, R7 forwarding, R8 range
    strap_mask = 1'b0;
    do_reset();
    sweep_windows("R5 R7 nibble base");

    // R10 side registers do not affect translation
    for (int i = 3; i < 8; i++) do_wr(12'(i * 4), 32'hFFFF_FFFF, 1'b1, 1'b0, "R10 side write");
    for (int w = 0; w < 3; w++) do_xl(2'(w), 32'h0000_1234, "R10 translation unchanged");

    // R6 masked variant sweep
    strap_mask = 1'b1;
    do_reset();
    sweep_windows("R6 R7 masked base");

    // R9 map write visible to the very next request
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 12'h008; wr_data = 32'h7654_3210; wr_word = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    shadow[2] = 32'h7654_3210;
    xl_valid = 1'b1; xl_win = 2'd2; xl_off = 32'h0000_0040;
    @(negedge clk);
    xl_valid = 1'b0;
    check_xl(1'b1, win_base(1'b1, 2, 32'h7654_3210) + 32'h40, "R9 back-to-back");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule